// File: doc/BRIEF.md
# Parallel flash command sequence decoder

This block is the command interpreter of a 16-bit-wide parallel NOR flash. It watches completed bus write cycles, each an address and a data word presented with a one-cycle write-valid pulse. It recognises the fixed-address unlock prefixes that guard every change to the array, and turns a complete, correct sequence into a one-cycle start pulse. The pulse carries the operation kind, the aligned target address and, for a program, the data word.

The same sequences move the device between plain array reads, a manufacturer/device identification mode and a capability query mode. A two-bit read-mode output tells the read path which source to use. For the two special modes, the block drives the returned word itself from a small built-in table. An external engine reports through `busy` that a program or erase is running. While it is high, every written command is ignored, the exit command included.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Writes of 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, followed by any fourth write, give `start` with `op_kind`=1 (program). `op_addr` and `op_data` equal the fourth write's address and data.
- R2: The erase sequence is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, then a sixth write. That write produces one of three erases. 0x30 gives `op_kind`=2 (sector), with `op_addr` the write address with bits 10..0 cleared. 0x50 gives `op_kind`=3 (block), with bits 14..0 cleared. 0x10 at 0x5555 gives `op_kind`=4 (chip), with `op_addr`=0.
- R3: Only address bits 14..0 and data bits 7..0 of a command write are compared. Upper address bits and data bits 15..8 do not affect decoding.
- R4: The prefix AA@5555, 55@2AAA ending in 0x90@5555 sets `read_mode`=1 (identification). Ending it in 0x98@5555 sets `read_mode`=2 (query).
- R5: A single 0xF0 write to any address returns `read_mode` to 0. So does the three-cycle prefix ending in 0xF0@5555.
- R6: A write that does not match the next expected cycle of a sequence sends the decoder back to read-array mode (`read_mode`=0) with no pending sequence. No start follows from it.
- R7: While `busy` is high, writes change neither the sequence state nor `read_mode`, and produce no start.
- R8: In identification mode, a read with `rd_addr` bits 17..1 all zero returns 0x00BF on `rd_data` when bit 0 is 0, and 0x272F when bit 0 is 1. Other addresses return 0. In query mode, address 0x10 returns 0x0051.
- R9: The state changes only on a write-valid cycle. Reads and idle cycles leave a pending sequence and the current mode untouched.
- R10: `start` is high for exactly one cycle. It appears in the cycle after the clock edge that samples the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle pulse: a bus write has completed |
| wr_addr | input | 18 | Address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Program or erase in progress in the array engine |
| rd_addr | input | 18 | Read address for the identification/query stub |
| start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| op_addr | output | 18 | Target address, aligned for erases |
| op_data | output | 16 | Program data |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |
| rd_data | output | 16 | Identification/query word for `rd_addr` (0 in array mode) |

## Verification
The embedded properties check these behaviours on every cycle:
- `start` never lasts two cycles.
- A write while busy neither starts anything nor shifts the mode.
- The mode never moves without a write.
- Erase addresses come out aligned.
- A lone 0xF0 from rest always lands in array mode.

Only the directed scenarios can show the following:
- Whole sequences are recognised at the right cycle, with the right address and data.
- A broken prefix leaves nothing pending.
- The don't-care bits really are ignored.
- The decoder has not quietly advanced while busy.

The bench shows the last point by writing a plain word after `busy` falls and observing that no program starts.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CMP_W    = 15,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  parameter logic [CMP_W-1:0] KEY_A = 15'h5555,
  parameter logic [CMP_W-1:0] KEY_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [1:0]        read_mode,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [2:0] K_PROG = 3'd1, K_SECT = 3'd2, K_BLK = 3'd3, K_CHIP = 3'd4;
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_QRY = 2'd2;
  localparam logic [DATA_W-1:0] MFR_CODE = 16'h00BF;
  localparam logic [DATA_W-1:0] DEV_CODE = 16'h272F;
  localparam logic [DATA_W-1:0] SIZE_LOG = DATA_W'(ADDR_W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3
  } seq_t;

  seq_t seq;
  logic [1:0] mode;
  logic [7:0] cmd;
  logic at_a, at_b, take, key1, key2;

  assign cmd  = wr_data[7:0];
  assign at_a = wr_addr[CMP_W-1:0] == KEY_A;
  assign at_b = wr_addr[CMP_W-1:0] == KEY_B;
  assign take = wr_valid && !busy;
  assign key1 = at_a && cmd == 8'hAA;
  assign key2 = at_b && cmd == 8'h55;
  assign read_mode = mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq     <= S_IDLE;
      mode    <= M_ARR;
      start   <= 1'b0;
      op_kind <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      start <= 1'b0;
      if (take) begin
        seq <= S_IDLE;
        case (seq)
          S_IDLE: if (key1) seq <= S_U1; else mode <= M_ARR;
          S_U1:   if (key2) seq <= S_U2; else mode <= M_ARR;
          S_U2: begin
            mode <= M_ARR;
            if (at_a) begin
              case (cmd)
                8'hA0: seq <= S_PROG;
                8'h80: seq <= S_E1;
                8'h90: mode <= M_ID;
                8'h98: mode <= M_QRY;
                default: ;
              endcase
            end
          end
          S_PROG: begin
            start   <= 1'b1;
            op_kind <= K_PROG;
            op_addr <= wr_addr;
            op_data <= wr_data;
          end
          S_E1: if (key1) seq <= S_E2;
          S_E2: if (key2) seq <= S_E3;
          S_E3: begin
            if (cmd == 8'h30) begin
              start   <= 1'b1;
              op_kind <= K_SECT;
              op_addr <= {wr_addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
            end else if (cmd == 8'h50) begin
              start   <= 1'b1;
              op_kind <= K_BLK;
              op_addr <= {wr_addr[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
            end else if (cmd == 8'h10 && at_a) begin
              start   <= 1'b1;
              op_kind <= K_CHIP;
              op_addr <= '0;
            end
          end
          default: mode <= M_ARR;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (mode)
      M_ID:
        if (rd_addr[ADDR_W-1:1] == '0) rd_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
      M_QRY:
        if (rd_addr[ADDR_W-1:8] == '0) begin
          case (rd_addr[7:0])
            8'h10: rd_data = 16'h0051;
            8'h11: rd_data = 16'h0052;
            8'h12: rd_data = 16'h0059;
            8'h27: rd_data = SIZE_LOG;
            default: rd_data = '0;
          endcase
        end
      default: rd_data = '0;
    endcase
  end

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> (!start && $stable(read_mode)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(read_mode));

  // R2
  sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_kind == K_SECT) |-> op_addr[SECT_LSB-1:0] == '0);

  // R2
  blk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_kind == K_BLK) |-> op_addr[BLK_LSB-1:0] == '0);

  // R5
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && seq == S_IDLE && cmd == 8'hF0) |=> read_mode == M_ARR);

endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic clk = 0, rst_n = 0, wr_valid = 0, busy = 0;
  logic [17:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic start;
  logic [2:0] op_kind;
  logic [17:0] op_addr;
  logic [15:0] op_data, rd_data;
  logic [1:0] read_mode;
  int checks = 0, fails = 0;
  logic g_start;
  logic [2:0] g_kind;
  logic [17:0] g_addr;
  logic [15:0] g_data;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
    g_start = start; g_kind = op_kind; g_addr = op_addr; g_data = op_data;
  endtask

  task automatic prefix(input logic [15:0] last);
    wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055); wr(18'h05555, last);
  endtask

  task automatic erase_pre();
    prefix(16'h0080); wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
  endtask

  task automatic t_reset();
    chk("R10 reset start", start, 0);
    chk("R4 reset mode", read_mode, 0);
  endtask

  task automatic t_program();
    prefix(16'h00A0);
    chk("R1 no early start", g_start, 0);
    wr(18'h31234, 16'hBEEF);
    chk("R1 start", g_start, 1);
    chk("R1 kind", g_kind, 1);
    chk("R1 addr", g_addr, 18'h31234);
    chk("R1 data", g_data, 16'hBEEF);
    @(negedge clk);
    chk("R10 one cycle", start, 0);
  endtask

  task automatic t_dontcare();
    wr(18'h25555, 16'hFFAA); wr(18'h1AAAA, 16'h3355); wr(18'h3D555, 16'h12A0);
    wr(18'h00042, 16'h5A5A);
    chk("R3 upper bits ignored start", g_start, 1);
    chk("R3 kind", g_kind, 1);
  endtask

  task automatic t_erase();
    erase_pre(); wr(18'h31ABC, 16'h0030);
    chk("R2 sector start", g_start, 1);
    chk("R2 sector kind", g_kind, 2);
    chk("R2 sector addr", g_addr, 18'h31800);
    erase_pre(); wr(18'h29ABC, 16'h0050);
    chk("R2 block kind", g_kind, 3);
    chk("R2 block addr", g_addr, 18'h28000);
    erase_pre(); wr(18'h05555, 16'h0010);
    chk("R2 chip kind", g_kind, 4);
    chk("R2 chip addr", g_addr, 0);
    erase_pre(); wr(18'h01234, 16'h0010);
    chk("R6 chip off-address no start", g_start, 0);
  endtask

  task automatic t_modes();
    prefix(16'h0090);
    chk("R4 id mode", read_mode, 1);
    rd_addr = 18'h0; #1; chk("R8 mfr code", rd_data, 16'h00BF);
    rd_addr = 18'h1; #1; chk("R8 dev code", rd_data, 16'h272F);
    rd_addr = 18'h21; #1; chk("R8 other addr", rd_data, 0);
    repeat (5) @(negedge clk);
    chk("R9 reads keep id", read_mode, 1);
    wr(18'h3FFFF, 16'h00F0);
    chk("R5 single exit", read_mode, 0);
    prefix(16'h0098);
    chk("R4 query mode", read_mode, 2);
    rd_addr = 18'h10; #1; chk("R8 query word", rd_data, 16'h0051);
    prefix(16'h00F0);
    chk("R5 prefixed exit", read_mode, 0);
  endtask

  task automatic t_abort();
    prefix(16'h0090);
    wr(18'h05555, 16'h00AA); wr(18'h01234, 16'h0055);
    chk("R6 abort to array", read_mode, 0);
    wr(18'h05555, 16'h00A0); wr(18'h00100, 16'h1234);
    chk("R6 no start after break", g_start, 0);
    prefix(16'h0077); wr(18'h00100, 16'h1234);
    chk("R6 bad third cycle", g_start, 0);
    wr(18'h05555, 16'h00AA);
    repeat (6) @(negedge clk);
    wr(18'h02AAA, 16'h0055); wr(18'h05555, 16'h00A0); wr(18'h00200, 16'h0F0F);
    chk("R9 idle gaps keep sequence", g_start, 1);
  endtask

  task automatic t_busy();
    busy = 1;
    prefix(16'h00A0);
    wr(18'h00300, 16'hAAAA);
    chk("R7 no start while busy", g_start, 0);
    busy = 0;
    wr(18'h00300, 16'h1111);
    chk("R7 state not advanced", g_start, 0);
    prefix(16'h0090);
    busy = 1;
    wr(18'h00000, 16'h00F0);
    chk("R7 exit ignored", read_mode, 1);
    busy = 0;
    wr(18'h00000, 16'h00F0);
    chk("R5 exit after busy", read_mode, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_dontcare();
    t_erase();
    t_modes();
    t_abort();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule